// File: doc/BRIEF.md
# Staggered Sense-Pulse Read Sequencer

This block runs the read half of a memory cycle on a board that stands in for magnetic core storage in an older computer. The host raises a read request with no relation to the board clock. The block synchronizes that request, waits a short settling interval so the host address is known to be stable, enables the memory chip, and then enables the chip's outputs. The word on the memory data bus is captured one cycle later.

The host expects to receive each bit as a low-going pulse on a sense line, one line per bit. A line is pulled low only for a bit that reads as 1. To keep the host's sense circuits from sinking too much current at once, the block does not pulse all lines together. It walks the returned vector in groups of three, one group per cycle, from the lowest bit upward. The host also expects two parity bits, one per byte. The block computes them from the captured word rather than keeping them in memory, and pulses them in the last group. After the last group the chip is released, and the block waits for the host to drop its request before it accepts another.

Top module: `stagger_read_seq`

## Requirements
- R1: After reset and while idle, `mem_ce_n`, `mem_oe_n` and all eighteen `sense_n` lines are high and `wbuf_en` is high.
- R2: `rd_req` passes through three flip-flops, and two settling cycles follow. If `rd_req` rises just before clock edge 1, `mem_ce_n` is still high after edge 5 and goes low at edge 6.
- R3: `mem_oe_n` goes low exactly one cycle after `mem_ce_n` goes low (edge 7), while `mem_ce_n` stays low.
- R4: The returned vector is ordered {P2, P1, data[15:0]}, with P1 at index 16 and P2 at index 17. It is sent over six consecutive cycles (edges 8 to 13), three indices per cycle in ascending order: 0–2, then 3–5, and so on up to 15, 16 and 17.
- R5: In its cycle, a sense line `sense_n[i]` is driven low only when returned bit i is 1. A 0 bit leaves its line high.
- R6: P1 makes data[7:0] plus P1 hold an odd number of ones. P2 does the same for data[15:8]. Both are computed from the word captured from memory.
- R7: `wbuf_en` is low during every cycle in which `mem_oe_n` is low.
- R8: Each sense pulse lasts exactly one cycle. All sense lines are high outside the six pulse cycles.
- R9: At the edge after the last group (edge 14), `mem_oe_n` and `mem_ce_n` both return high. No new read starts while `rd_req` stays high. A new read starts only after `rd_req` has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Asynchronous read request from the host, active high |
| mem_dq | input | 16 | Data bus from the memory chip |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| wbuf_en | output | 1 | Enable of the buffers that drive the memory bus, high while idle |
| sense_n | output | 18 | Per-bit sense pulses to the host, active low, {P2, P1, data} |

## Verification
If the sequencer takes a wrong state, the error shows at the ports within one cycle. A skipped or repeated step moves a sense group to the wrong cycle or duplicates it. A wrong settle or synchronizer count shifts the chip-enable edge away from edge 6. A lost rearm condition starts a second read while the request is still high. A corrupted capture register or parity function shows up as a wrong three-bit slice, at latest in the sixth pulse cycle, where P1 and P2 appear.

// File: rtl/sns_pkg.sv
package sns_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CE_ON,
    ST_OE_ON,
    ST_PULSE,
    ST_CLOSE,
    ST_REARM
  } seq_state_t;

  // odd parity over one byte: result makes total ones odd
  function automatic logic odd_par8(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/sns_sync.sv
module sns_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= 1'b0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sns_parity.sv
module sns_parity #(
  parameter int DATA_W = 16,
  localparam int NBYTE = DATA_W / 8
) (
  input  logic [DATA_W-1:0] word,
  output logic [NBYTE-1:0]  par
);
  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign par[i] = sns_pkg::odd_par8(word[8*i +: 8]);
  end
endmodule

// File: rtl/sns_group_drive.sv
module sns_group_drive #(
  parameter int RET_W = 18,
  parameter int GRP   = 3,
  localparam int N_GRP = RET_W / GRP
) (
  input  logic [RET_W-1:0] ret_vec,
  input  logic [N_GRP-1:0] grp_act,
  output logic [RET_W-1:0] sense_n
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    for (genvar b = 0; b < GRP; b++) begin : g_bit
      assign sense_n[g*GRP+b] = ~(grp_act[g] & ret_vec[g*GRP+b]);
    end
  end
endmodule

// File: rtl/sns_seq.sv
module sns_seq #(
  parameter int N_GRP  = 6,
  parameter int SETTLE = 2,
  localparam int GW = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_s,
  output logic             ce_n,
  output logic             oe_n,
  output logic             wbuf_en,
  output logic             capture,
  output logic [N_GRP-1:0] grp_act
);
  import sns_pkg::*;

  seq_state_t      state;
  logic [GW-1:0]   grp_idx;
  logic [SW-1:0]   set_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      grp_idx <= '0;
      set_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_s) begin
          state   <= ST_SETTLE;
          set_cnt <= '0;
        end
        ST_SETTLE: begin
          if (set_cnt == SW'(SETTLE-1)) state <= ST_CE_ON;
          else                          set_cnt <= set_cnt + 1'b1;
        end
        ST_CE_ON: state <= ST_OE_ON;
        ST_OE_ON: begin
          state   <= ST_PULSE;
          grp_idx <= '0;
        end
        ST_PULSE: begin
          if (grp_idx == GW'(N_GRP-1)) state <= ST_CLOSE;
          else                         grp_idx <= grp_idx + 1'b1;
        end
        ST_CLOSE: state <= ST_REARM;
        ST_REARM: if (!req_s) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign ce_n    = !(state inside {ST_CE_ON, ST_OE_ON, ST_PULSE});
  assign oe_n    = !(state inside {ST_OE_ON, ST_PULSE});
  assign wbuf_en = (state == ST_IDLE);
  assign capture = (state == ST_OE_ON);

  for (genvar g = 0; g < N_GRP; g++) begin : g_act
    assign grp_act[g] = (state == ST_PULSE) && (grp_idx == GW'(g));
  end
endmodule

// File: rtl/stagger_read_seq.sv
module stagger_read_seq #(
  parameter int DATA_W      = 16,
  parameter int GRP         = 3,
  parameter int SYNC_STAGES = 3,
  parameter int SETTLE      = 2,
  localparam int RET_W = DATA_W + DATA_W / 8,
  localparam int N_GRP = RET_W / GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [DATA_W-1:0] mem_dq,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             wbuf_en,
  output logic [RET_W-1:0] sense_n
);
  logic              req_sync;
  logic              capture;
  logic [N_GRP-1:0]  grp_act;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W/8-1:0] par;

  sns_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rd_req), .sync_out(req_sync)
  );

  sns_seq #(.N_GRP(N_GRP), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_s(req_sync),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .wbuf_en(wbuf_en),
    .capture(capture), .grp_act(grp_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (capture) word_q <= mem_dq;
  end

  sns_parity #(.DATA_W(DATA_W)) u_par (.word(word_q), .par(par));

  sns_group_drive #(.RET_W(RET_W), .GRP(GRP)) u_drv (
    .ret_vec({par, word_q}), .grp_act(grp_act), .sense_n(sense_n)
  );
endmodule

// File: rtl/sns_checker.sv
module sns_checker #(
  parameter int RET_W = 18,
  parameter int N_GRP = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             oe_n,
  input logic             wbuf_en,
  input logic             req_sync,
  input logic [RET_W-1:0] sense_n,
  input logic [N_GRP-1:0] grp_act
);
  assert_wbuf_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !wbuf_en);

  assert_oe_after_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> (!ce_n && !$past(ce_n)));

  assert_quiet_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (&sense_n));

  assert_single_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_act));

  assert_group_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_act != '0 && !grp_act[N_GRP-1]) |=> (grp_act == ($past(grp_act) << 1)));

  assert_parity_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_n[RET_W-1] || !sense_n[RET_W-2]) |-> grp_act[N_GRP-1]);

  assert_start_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> req_sync);
endmodule

bind stagger_read_seq sns_checker #(.RET_W(RET_W), .N_GRP(N_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
  .wbuf_en(wbuf_en), .req_sync(req_sync), .sense_n(sense_n), .grp_act(grp_act)
);

// File: tb/stagger_read_seq_bench.sv
module stagger_read_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [15:0] word_mem = 16'h0000;
  logic [15:0] mem_dq;
  logic        mem_ce_n, mem_oe_n, wbuf_en;
  logic [17:0] sense_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [17:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: valid word only with both enables low
  assign mem_dq = (!mem_ce_n && !mem_oe_n) ? word_mem : ~word_mem;

  stagger_read_seq u_stagger_read_seq (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .mem_dq(mem_dq),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .wbuf_en(wbuf_en),
    .sense_n(sense_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic par_odd(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) if (b[i]) n++;
    return (n % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  // driver: push expected sense patterns, run one read
  task automatic do_read(input logic [15:0] w);
    logic [17:0] ret;
    ret = {par_odd(w[15:8]), par_odd(w[7:0]), w};  // R6: P1 idx16, P2 idx17
    for (int g = 0; g < 6; g++) begin
      logic [17:0] m;
      m = 18'h7 << (3*g);
      exp_q.push_back(~(ret & m));                   // R4 R5
    end
    word_mem = w;
    @(negedge clk);
    rd_req = 1'b1;
    for (int c = 1; c <= 20; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == 5) check(mem_ce_n === 1'b1, "R2 ce early", mem_ce_n, 1);
      if (c == 6) check(mem_ce_n === 1'b0 && mem_oe_n === 1'b1, "R2 ce edge",
                        {mem_ce_n, mem_oe_n}, 2'b01);
      if (c == 7) check(mem_ce_n === 1'b0 && mem_oe_n === 1'b0, "R3 oe edge",
                        {mem_ce_n, mem_oe_n}, 2'b00);
      if (c == 14) check(mem_ce_n === 1'b1 && mem_oe_n === 1'b1, "R9 release",
                         {mem_ce_n, mem_oe_n}, 2'b11);
      if (c == 20) check(mem_ce_n === 1'b1, "R9 no restart while high", mem_ce_n, 1);
    end
    rd_req = 1'b0;
    for (int c = 0; c < 6; c++) @(negedge clk);
    check(exp_q.size() == 0, "R4 all groups seen", exp_q.size(), 0);
  endtask

  // monitor
  initial begin
    logic prev_oe_n;
    prev_oe_n = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!mem_oe_n) check(wbuf_en === 1'b0, "R7 buffers off", wbuf_en, 0);
        if (!mem_oe_n && !prev_oe_n) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected group", sense_n, 18'h3ffff);
          end else begin
            logic [17:0] e;
            e = exp_q.pop_front();
            check(sense_n === e, "R4 R5 R6 group slice", sense_n, e);
          end
        end else begin
          check(sense_n === 18'h3ffff, "R8 lines idle", sense_n, 18'h3ffff);
        end
        prev_oe_n = mem_oe_n;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [7];
    pats = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'hAAAA, 16'h5555, 16'h00FF};
    repeat (3) @(negedge clk);
    check(mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && wbuf_en === 1'b1 &&
          sense_n === 18'h3ffff, "R1 reset state",
          {mem_ce_n, mem_oe_n, wbuf_en, sense_n}, {3'b111, 18'h3ffff});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_ce_n === 1'b1 && wbuf_en === 1'b1, "R1 idle", {mem_ce_n, wbuf_en}, 2'b11);
    foreach (pats[i]) do_read(pats[i]);
    for (int k = 0; k < 12; k++) do_read(16'($urandom));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule